// File: doc/BRIEF.md
# Iterative Multiply Divide Unit

This block is a small memory-mapped arithmetic engine. It has two operations: an unsigned 8 by 8 multiply that gives a 16-bit product, and an unsigned 16 by 8 divide that gives a 16-bit quotient and a remainder. Software writes the operands through a byte-wide write port. Writing the last operand of an operation starts that operation. The engine then advances one bit on each cycle in which the cycle-enable strobe is high. The result registers change while the operation runs, so a reader that comes back early sees a partial value.

The divide writes its quotient to a dedicated 16-bit register. The product of a multiply and the remainder of a divide share a second 16-bit register. Both registers are read one byte at a time through a read-select input. A busy output is high from the start write until the last step has been taken.

Top module: `md_unit`

## Requirements
- R1: After reset, busy is 0, both result registers read 0, the multiplicand holds 0xFF and the dividend holds 0xFFFF. A multiply or divide started without rewriting those operands uses the reset values.
- R2: A write to address 1 (multiplier) starts a multiply. Busy stays high for exactly 8 strobed cycles, and the product register then holds multiplicand times multiplier.
- R3: During a multiply, after k strobed cycles the product register holds the multiplicand times the multiplier masked to its k least significant bits.
- R4: A write to address 4 (divisor) starts a divide. Busy stays high for exactly 16 strobed cycles, and the quotient and remainder registers then hold the dividend divided by the divisor and the dividend modulo the divisor.
- R5: During a divide by a nonzero divisor, after k strobed cycles the quotient register holds the dividend's top k bits divided by the divisor, and the remainder register holds the same top k bits modulo the divisor.
- R6: Dividing by zero ends with quotient 0xFFFF and remainder equal to the dividend.
- R7: A start write made while an operation is running abandons that operation. The new operation runs for its full step count using the operand values held at that moment.
- R8: Cycles with cyc_en low do not advance an operation and do not change the results.
- R9: A multiply does not change the quotient register.
- R10: Write addresses are: 0 multiplicand, 1 multiplier (starts a multiply), 2 dividend low byte, 3 dividend high byte, 4 divisor (starts a divide). Read selects are: 0 quotient low byte, 1 quotient high byte, 2 product/remainder low byte, 3 product/remainder high byte.
- R11: Rewriting the multiplicand or the dividend while an operation runs does not alter that operation's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| cyc_en | input | 1 | Strobe for one processor cycle; each high cycle advances one step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 2 | Result byte select |
| rd_data | output | 8 | Selected result byte |
| busy | output | 1 | High while an operation is in progress |

## Verification
The multiply is run with the reset multiplicand, with a mixed bit pattern sampled at the halfway point, and with the largest operands. These runs separate a wrong bit order or a dropped carry from a correct shift-and-add. The divide is run with the reset dividend, with an awkward divisor sampled partway through, and with a zero divisor. Together they expose restoring errors, a wrong quotient bit order and a special-cased divide by zero. Further runs stop the strobe in the middle of an operation, restart an operation over a running one, and rewrite an operand mid-operation. These show that the step counter and the working copies of the operands behave independently of the visible operand registers.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic { OP_MUL = 1'b0, OP_DIV = 1'b1 } md_op_e;

  localparam logic [2:0] WA_MCAND   = 3'd0;
  localparam logic [2:0] WA_MPLIER  = 3'd1;
  localparam logic [2:0] WA_DVD_LO  = 3'd2;
  localparam logic [2:0] WA_DVD_HI  = 3'd3;
  localparam logic [2:0] WA_DIVISOR = 3'd4;

  localparam logic [1:0] RS_QUO_LO = 2'd0;
  localparam logic [1:0] RS_QUO_HI = 2'd1;
  localparam logic [1:0] RS_RES_LO = 2'd2;
  localparam logic [1:0] RS_RES_HI = 2'd3;
endpackage

// File: rtl/md_operands.sv
module md_operands
  import md_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [OP_W-1:0]   wr_data,
  output logic [OP_W-1:0]   mcand_q,
  output logic [2*OP_W-1:0] dvd_q,
  output logic              start_mul,
  output logic              start_div
);
  logic [OP_W-1:0]   mcand_d;
  logic [2*OP_W-1:0] dvd_d;

  assign start_mul = wr_en && (wr_addr == WA_MPLIER);
  assign start_div = wr_en && (wr_addr == WA_DIVISOR);

  always_comb begin
    mcand_d = mcand_q;
    dvd_d   = dvd_q;
    if (wr_en) begin
      case (wr_addr)
        WA_MCAND:  mcand_d = wr_data;
        WA_DVD_LO: dvd_d[OP_W-1:0] = wr_data;
        WA_DVD_HI: dvd_d[2*OP_W-1:OP_W] = wr_data;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '1;
      dvd_q   <= '1;
    end else begin
      mcand_q <= mcand_d;
      dvd_q   <= dvd_d;
    end
  end

  // R1: operand registers move only on a write to their own address
  p_mcand_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == WA_MCAND) |=> $stable(mcand_q));
endmodule

// File: rtl/md_seq.sv
module md_seq
  import md_pkg::*;
#(
  parameter int MUL_STEPS = 8,
  parameter int DIV_STEPS = 16,
  localparam int CNT_W = $clog2(DIV_STEPS + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_mul,
  input  logic   start_div,
  input  logic   cyc_en,
  output logic   busy,
  output md_op_e op,
  output logic   step_en
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  md_op_e           op_q, op_d;
  logic             start_any;

  assign start_any = start_mul || start_div;
  assign step_en   = busy_q && cyc_en && !start_any;
  assign busy      = busy_q;
  assign op        = op_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    op_d   = op_q;
    if (start_mul) begin
      cnt_d  = CNT_W'(MUL_STEPS);
      busy_d = 1'b1;
      op_d   = OP_MUL;
    end else if (start_div) begin
      cnt_d  = CNT_W'(DIV_STEPS);
      busy_d = 1'b1;
      op_d   = OP_DIV;
    end else if (step_en) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      op_q   <= OP_MUL;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      op_q   <= op_d;
    end
  end

  // R7: any start write leaves the engine busy on the next cycle
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_any |=> busy_q);
  // R2: busy never rises without a start write
  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_any) |=> !busy_q);
  // R8: no strobe and no start keeps the step count
  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !start_any) |=> $stable(cnt_q));
endmodule

// File: rtl/md_mul_step.sv
module md_mul_step #(
  parameter int RES_W = 16
) (
  input  logic [RES_W-1:0] acc,
  input  logic [RES_W-1:0] addend,
  input  logic             take,
  output logic [RES_W-1:0] acc_nxt
);
  always_comb begin
    acc_nxt = take ? (acc + addend) : acc;
  end
endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
  parameter int OP_W = 8,
  localparam int RES_W = 2 * OP_W
) (
  input  logic [RES_W-1:0] rem,
  input  logic             in_bit,
  input  logic [OP_W-1:0]  divisor,
  output logic [RES_W-1:0] rem_nxt,
  output logic             q_bit
);
  logic [RES_W:0] trial;
  logic [RES_W:0] dvs_ext;

  always_comb begin
    trial   = {rem, in_bit};
    dvs_ext = {{(RES_W+1-OP_W){1'b0}}, divisor};
    q_bit   = (trial >= dvs_ext);
    rem_nxt = q_bit ? RES_W'(trial - dvs_ext) : RES_W'(trial);
  end
endmodule

// File: rtl/md_unit.sv
module md_unit
  import md_pkg::*;
#(
  parameter int OP_W = 8,
  localparam int RES_W = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_en,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [OP_W-1:0] wr_data,
  input  logic [1:0]      rd_sel,
  output logic [OP_W-1:0] rd_data,
  output logic            busy
);
  logic [OP_W-1:0]  mcand_q;
  logic [RES_W-1:0] dvd_q;
  logic             start_mul, start_div, step_en;
  md_op_e           op;

  logic [RES_W-1:0] acc_q, acc_d;
  logic [RES_W-1:0] quo_q, quo_d;
  logic [RES_W-1:0] wa_q, wa_d;
  logic [OP_W-1:0]  wb_q, wb_d;
  logic [RES_W-1:0] mul_nxt, div_nxt;
  logic             q_bit;

  md_operands #(.OP_W(OP_W)) u_ops (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mcand_q(mcand_q), .dvd_q(dvd_q),
    .start_mul(start_mul), .start_div(start_div)
  );

  md_seq #(.MUL_STEPS(OP_W), .DIV_STEPS(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_mul(start_mul), .start_div(start_div),
    .cyc_en(cyc_en), .busy(busy), .op(op), .step_en(step_en)
  );

  md_mul_step #(.RES_W(RES_W)) u_mul (
    .acc(acc_q), .addend(wa_q), .take(wb_q[0]), .acc_nxt(mul_nxt)
  );

  md_div_step #(.OP_W(OP_W)) u_div (
    .rem(acc_q), .in_bit(wa_q[RES_W-1]), .divisor(wb_q),
    .rem_nxt(div_nxt), .q_bit(q_bit)
  );

  // wa: shifted multiplicand (multiply) or shifted dividend (divide)
  // wb: multiplier shifted right (multiply) or divisor (divide)
  always_comb begin
    acc_d = acc_q;
    quo_d = quo_q;
    wa_d  = wa_q;
    wb_d  = wb_q;
    if (start_mul) begin
      acc_d = '0;
      wa_d  = {{(RES_W-OP_W){1'b0}}, mcand_q};
      wb_d  = wr_data;
    end else if (start_div) begin
      acc_d = '0;
      quo_d = '0;
      wa_d  = dvd_q;
      wb_d  = wr_data;
    end else if (step_en) begin
      if (op == OP_MUL) begin
        acc_d = mul_nxt;
        wa_d  = wa_q << 1;
        wb_d  = wb_q >> 1;
      end else begin
        acc_d = div_nxt;
        quo_d = {quo_q[RES_W-2:0], q_bit};
        wa_d  = wa_q << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      quo_q <= '0;
      wa_q  <= '0;
      wb_q  <= '0;
    end else begin
      acc_q <= acc_d;
      quo_q <= quo_d;
      wa_q  <= wa_d;
      wb_q  <= wb_d;
    end
  end

  always_comb begin
    case (rd_sel)
      RS_QUO_LO: rd_data = quo_q[OP_W-1:0];
      RS_QUO_HI: rd_data = quo_q[RES_W-1:OP_W];
      RS_RES_LO: rd_data = acc_q[OP_W-1:0];
      default:   rd_data = acc_q[RES_W-1:OP_W];
    endcase
  end

  // R8: results hold when no step and no start
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !start_mul && !start_div) |=> ($stable(acc_q) && $stable(quo_q)));
  // R9: a multiply step leaves the quotient alone
  p_mul_quo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_MUL && !start_div) |=> $stable(quo_q));
  // R4: remainder stays below a nonzero divisor during a divide
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_DIV && wb_q != '0) |-> (acc_q < {{(RES_W-OP_W){1'b0}}, wb_q}));
  // R6: with a zero divisor every divide step shifts in a one
  p_zero_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == OP_DIV && wb_q == '0) |=> (quo_q == {$past(quo_q[RES_W-2:0]), 1'b1}));
endmodule

// File: tb/md_unit_tb_top.sv
`timescale 1ns/1ps
module md_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       busy;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  md_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; cyc_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      cyc_en = 1'b1;
      @(negedge clk);
    end
    cyc_en = 1'b0;
  endtask

  task automatic rd_byte(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s;
    #0.5;
    v = rd_data;
  endtask

  task automatic rd16(input logic [1:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd_byte(lo, l);
    rd_byte(lo + 2'd1, h);
    v = {h, l};
  endtask

  task automatic t_reset_state;
    logic [15:0] q, r;
    rd16(2'd0, q); rd16(2'd2, r);
    chk("R1 busy after reset", busy, 0);
    chk("R1 quotient after reset", q, 0);
    chk("R1 result after reset", r, 0);
  endtask

  task automatic t_div_reset_dividend;
    logic [15:0] q, r;
    wr(3'd4, 8'h10);
    steps(16);
    rd16(2'd0, q); rd16(2'd2, r);
    chk("R1 reset dividend quotient", q, 16'hFFFF / 16'h10);
    chk("R1 reset dividend remainder", r, 16'hFFFF % 16'h10);
  endtask

  task automatic t_mul_reset_mcand;
    logic [15:0] q, r;
    wr(3'd1, 8'h02);
    steps(7);
    chk("R2 busy after 7 steps", busy, 1);
    steps(1);
    chk("R2 busy after 8 steps", busy, 0);
    rd16(2'd2, r); rd16(2'd0, q);
    chk("R1 reset multiplicand product", r, 16'h01FE);
    chk("R9 quotient kept by multiply", q, 16'hFFFF / 16'h10);
  endtask

  task automatic t_mul_pattern;
    logic [15:0] r;
    wr(3'd0, 8'hC3);
    wr(3'd1, 8'h5A);
    steps(4);
    rd16(2'd2, r);
    chk("R3 partial product after 4 steps", r, 16'hC3 * (16'h5A & 16'h0F));
    steps(4);
    rd16(2'd2, r);
    chk("R2 product C3*5A", r, 16'hC3 * 16'h5A);
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'hFF);
    steps(8);
    rd16(2'd2, r);
    chk("R2 product FF*FF", r, 16'hFE01);
  endtask

  task automatic t_div_pattern;
    logic [15:0] q, r;
    logic [7:0] b;
    wr(3'd2, 8'hEF);
    wr(3'd3, 8'hBE);
    wr(3'd4, 8'h37);
    steps(10);
    rd16(2'd0, q); rd16(2'd2, r);
    chk("R5 partial quotient after 10 steps", q, (16'hBEEF >> 6) / 16'h37);
    chk("R5 partial remainder after 10 steps", r, (16'hBEEF >> 6) % 16'h37);
    steps(5);
    chk("R4 busy after 15 steps", busy, 1);
    steps(1);
    chk("R4 busy after 16 steps", busy, 0);
    rd16(2'd0, q); rd16(2'd2, r);
    chk("R4 quotient BEEF/37", q, 16'hBEEF / 16'h37);
    chk("R4 remainder BEEF/37", r, 16'hBEEF % 16'h37);
    rd_byte(2'd1, b);
    chk("R10 quotient high byte", b, (16'hBEEF / 16'h37) >> 8);
    rd_byte(2'd2, b);
    chk("R10 remainder low byte", b, 16'hBEEF % 16'h37);
  endtask

  task automatic t_div_zero;
    logic [15:0] q, r;
    wr(3'd2, 8'h34);
    wr(3'd3, 8'h12);
    wr(3'd4, 8'h00);
    steps(8);
    rd16(2'd0, q); rd16(2'd2, r);
    chk("R6 zero divisor partial quotient", q, 16'h00FF);
    chk("R6 zero divisor partial remainder", r, 16'h0012);
    steps(8);
    rd16(2'd0, q); rd16(2'd2, r);
    chk("R6 zero divisor quotient", q, 16'hFFFF);
    chk("R6 zero divisor remainder", r, 16'h1234);
  endtask

  task automatic t_restart;
    logic [15:0] q, r;
    wr(3'd0, 8'h09);
    wr(3'd1, 8'h07);
    steps(3);
    wr(3'd2, 8'hE8);
    wr(3'd3, 8'h03);
    wr(3'd4, 8'h09);
    steps(15);
    chk("R7 restarted divide busy at 15", busy, 1);
    steps(1);
    chk("R7 restarted divide done at 16", busy, 0);
    rd16(2'd0, q); rd16(2'd2, r);
    chk("R7 restarted quotient", q, 16'd1000 / 16'd9);
    chk("R7 restarted remainder", r, 16'd1000 % 16'd9);
    wr(3'd1, 8'h03);
    steps(5);
    wr(3'd1, 8'h0B);
    steps(7);
    chk("R7 restarted multiply busy at 7", busy, 1);
    steps(1);
    rd16(2'd2, r);
    chk("R7 restarted multiply product", r, 16'd9 * 16'd11);
  endtask

  task automatic t_gating;
    logic [15:0] r0, r1;
    wr(3'd0, 8'h6D);
    wr(3'd1, 8'hB7);
    steps(2);
    rd16(2'd2, r0);
    repeat (6) @(negedge clk);
    rd16(2'd2, r1);
    chk("R8 result held without strobe", r1, r0);
    chk("R8 busy held without strobe", busy, 1);
    steps(5);
    chk("R8 busy after 7 strobed steps", busy, 1);
    steps(1);
    rd16(2'd2, r1);
    chk("R8 product after gated run", r1, 16'h6D * 16'hB7);
  endtask

  task automatic t_operand_midway;
    logic [15:0] q, r;
    wr(3'd0, 8'h11);
    wr(3'd1, 8'h0F);
    steps(3);
    wr(3'd0, 8'hFF);
    steps(5);
    rd16(2'd2, r);
    chk("R11 multiplicand rewrite ignored", r, 16'h00FF);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h40);
    wr(3'd4, 8'h07);
    steps(4);
    wr(3'd3, 8'h01);
    wr(3'd2, 8'h55);
    steps(12);
    rd16(2'd0, q); rd16(2'd2, r);
    chk("R11 dividend rewrite ignored quotient", q, 16'h4000 / 16'd7);
    chk("R11 dividend rewrite ignored remainder", r, 16'h4000 % 16'd7);
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_div_reset_dividend();
    t_mul_reset_mcand();
    t_mul_pattern();
    t_div_pattern();
    t_div_zero();
    t_restart();
    t_gating();
    t_operand_midway();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule